// File: doc/BRIEF.md
# Cascaded Tree Sum Reduction Engine

This engine adds up a run of `n` signed integers with `LANES` parallel accumulators, where `LANES` is a power of two from 1 to 512. A start pulse loads the run length. Input then arrives over a valid/ready stream, two elements per beat. Each beat goes to one lane, and that lane adds both elements into its own accumulator in a single step. The beats walk the run in rounds of `2*LANES` positions. When the last beat has been taken, a tree of halving strides folds the accumulators together. At each stride, every lane below the stride adds in the entry one stride above it, so the working lanes are always the lowest indices. The grand total ends up in entry 0 and is presented on the result port with a one-cycle valid pulse.

The producer has to lay out the pairs the way the engine expects. Beat `b` carries the element at round position `lane` in its low half and the element `LANES` positions later in its high half. Any element that would fall past the end of the run counts as zero. A run of length zero produces a zero result and takes no beats.

Top module: `cascade_sum_top`

## Requirements
- R1: While reset is held and at the first sample after reset, `inReady` and `resValid` are both low.
- R2: A start pulse seen while idle captures `len` as n. The engine then takes exactly floor(n/(2P))·P + min(n mod 2P, P) beats, with P = LANES. `inReady` is low at every other time.
- R3: Beat b is handled by lane b mod P in round b div P. Bits [DATA_W-1:0] hold the element at position round·2P + lane. Bits [2·DATA_W-1:DATA_W] hold the element at position round·2P + lane + P. Both are added into that lane's accumulator, which is cleared to zero at start.
- R4: The high half of a beat is ignored when its position is n or greater. The value driven there has no effect on the result.
- R5: Once loading ends, the engine runs strides P/2, P/4, …, 1. At each stride, lane t < s adds entry t+s into entry t. `resData` then equals the sum of the n elements modulo 2^DATA_W, as two's-complement wrap with no overflow indication.
- R6: `resValid` is high in the cycle that follows the (log2 P + 1)-th rising edge after the edge that accepts the last beat. When n = 0, the count starts from the edge that captures the start pulse.
- R7: With n = 0, the result is zero and no beat is accepted.
- R8: `resValid` is high for exactly one cycle. `resData` keeps the total until the next start.
- R9: A start pulse that arrives while a run is in progress is ignored. It changes neither the beat count nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| len | input | LEN_W | Number of elements in the run, sampled with `start` |
| inValid | input | 1 | Producer offers a beat |
| inData | input | 2*DATA_W | Element pair: low half at the lane position, high half `LANES` positions later |
| inReady | output | 1 | Engine takes the beat in this cycle |
| resValid | output | 1 | One-cycle pulse marking the total |
| resData | output | DATA_W | Total of the run, held until the next start |

## Verification
The bench builds the engine with `LANES=4`, `DATA_W=16` and `LEN_W=10`. With four lanes, a round is eight positions, so short random runs produce every shape of final round: full rounds, rounds that only fill some low halves, and rounds that cut a high half off. Each of these shapes changes the beat count and the masking. The 16-bit data width lets a few dozen large values wrap the sum, and a two-level tree makes the completion latency visible and distinct from the single-lane case.

// File: rtl/cascade_sum_pkg.sv
package cascade_sum_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_TREE,
    ST_DONE
  } sumState_t;

  // Strobes from the sequencer to the accumulator array.
  typedef struct packed {
    logic clearAcc;
    logic loadBeat;
    logic maskHigh;
    logic treeStep;
  } sumCtrl_t;

endpackage

// File: rtl/cascade_sum_ctrl.sv
module cascade_sum_ctrl
  import cascade_sum_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LEN_W = 16,
  localparam int LOG_P = $clog2(LANES),
  localparam int LANE_W = (LOG_P > 0) ? LOG_P : 1,
  localparam int SW = LOG_P + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  logic              inValid,
  output logic              inReady,
  output logic              resValid,
  output sumCtrl_t          ctrl,
  output logic [LANE_W-1:0] laneSel,
  output logic [SW-1:0]     stride
);

  localparam int POS_W = LEN_W + LOG_P + 2;

  sumState_t        state, stateNext;
  logic [LEN_W-1:0] lenReg;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] lenWide;
  logic             posLive;

  assign lenWide = POS_W'(lenReg);
  assign posLive = pos < lenWide;
  assign laneSel = pos[LANE_W-1:0] & LANE_W'(LANES - 1);

  always_comb begin
    ctrl      = '0;
    inReady   = 1'b0;
    resValid  = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.clearAcc = 1'b1;
          stateNext     = ST_LOAD;
        end
      end
      ST_LOAD: begin
        inReady = posLive;
        if (posLive) begin
          if (inValid) begin
            ctrl.loadBeat = 1'b1;
            ctrl.maskHigh = (pos + POS_W'(LANES)) >= lenWide;
          end
        end else begin
          stateNext = (LOG_P == 0) ? ST_DONE : ST_TREE;
        end
      end
      ST_TREE: begin
        ctrl.treeStep = 1'b1;
        if (stride <= SW'(1)) stateNext = ST_DONE;
      end
      ST_DONE: begin
        resValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      lenReg <= '0;
      pos    <= '0;
      stride <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && start) begin
        lenReg <= len;
        pos    <= '0;
        stride <= SW'(LANES / 2);
      end
      if (ctrl.loadBeat) begin
        // after the last lane of a round, skip the high-half positions
        if (laneSel == LANE_W'(LANES - 1)) pos <= pos + POS_W'(LANES + 1);
        else                               pos <= pos + POS_W'(1);
      end
      if (ctrl.treeStep) stride <= stride >> 1;
    end
  end

  // R8: the completion flag never lasts two cycles
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |=> !resValid);

  // R9: the captured length cannot move once a run is under way
  a_r9_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(lenReg));

  // R7: an empty run never opens the input
  a_r7_empty_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && len == '0) |=> !inReady);

  // R5: the tree never overlaps with input acceptance
  a_r5_tree_not_loading: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.treeStep |-> !inReady);

  // R5: strides only shrink during the tree phase
  a_r5_stride_halves: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.treeStep |=> (stride == ($past(stride) >> 1)));

endmodule

// File: rtl/cascade_sum_dpath.sv
module cascade_sum_dpath
  import cascade_sum_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DATA_W = 32,
  localparam int LOG_P = $clog2(LANES),
  localparam int LANE_W = (LOG_P > 0) ? LOG_P : 1,
  localparam int SW = LOG_P + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  sumCtrl_t            ctrl,
  input  logic [LANE_W-1:0]   laneSel,
  input  logic [SW-1:0]       stride,
  input  logic [2*DATA_W-1:0] inData,
  output logic [DATA_W-1:0]   resData
);

  logic [DATA_W-1:0] acc     [LANES];
  logic [DATA_W-1:0] term    [LANES][LANE_W];
  logic [DATA_W-1:0] partner [LANES];
  logic [DATA_W-1:0] lowElem, highElem, pairSum;

  assign lowElem  = inData[DATA_W-1:0];
  assign highElem = ctrl.maskHigh ? '0 : inData[2*DATA_W-1:DATA_W];
  assign pairSum  = lowElem + highElem;

  // Each lane can only ever be paired with entries a power of two above it.
  for (genvar t = 0; t < LANES; t++) begin : g_lane
    for (genvar k = 0; k < LANE_W; k++) begin : g_step
      if (k < LOG_P && t < (1 << k)) begin : g_pair
        assign term[t][k] = stride[k] ? acc[t + (1 << k)] : '0;
      end else begin : g_none
        assign term[t][k] = '0;
      end
    end
  end

  always_comb begin
    for (int t = 0; t < LANES; t++) begin
      partner[t] = '0;
      for (int k = 0; k < LANE_W; k++) partner[t] = partner[t] | term[t][k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < LANES; t++) acc[t] <= '0;
    end else begin
      for (int t = 0; t < LANES; t++) begin
        if (ctrl.clearAcc)
          acc[t] <= '0;
        else if (ctrl.loadBeat && laneSel == LANE_W'(t))
          acc[t] <= acc[t] + pairSum;
        else if (ctrl.treeStep)
          acc[t] <= acc[t] + partner[t];
      end
    end
  end

  assign resData = acc[0];

  // R3: a start clears the accumulators
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clearAcc |=> (acc[0] == '0));

  // R8: the total is held while the engine sits idle
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.clearAcc || ctrl.loadBeat || ctrl.treeStep) |=> $stable(acc[0]));

endmodule

// File: rtl/cascade_sum_top.sv
module cascade_sum_top
  import cascade_sum_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DATA_W = 32,
  parameter int LEN_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LEN_W-1:0]    len,
  input  logic                inValid,
  input  logic [2*DATA_W-1:0] inData,
  output logic                inReady,
  output logic                resValid,
  output logic [DATA_W-1:0]   resData
);

  localparam int LOG_P = $clog2(LANES);
  localparam int LANE_W = (LOG_P > 0) ? LOG_P : 1;
  localparam int SW = LOG_P + 1;

  sumCtrl_t          ctrl;
  logic [LANE_W-1:0] laneSel;
  logic [SW-1:0]     stride;

  cascade_sum_ctrl #(.LANES(LANES), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len),
    .inValid(inValid), .inReady(inReady), .resValid(resValid),
    .ctrl(ctrl), .laneSel(laneSel), .stride(stride)
  );

  cascade_sum_dpath #(.LANES(LANES), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .laneSel(laneSel),
    .stride(stride), .inData(inData), .resData(resData)
  );

endmodule

// File: tb/cascade_sum_top_tb.sv
module cascade_sum_top_tb;

  localparam int P = 4;
  localparam int DW = 16;
  localparam int LW = 10;
  localparam int LOGP = $clog2(P);
  localparam int MAXN = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] len = '0;
  logic          inValid = 1'b0;
  logic [2*DW-1:0] inData = '0;
  logic          inReady, resValid;
  logic [DW-1:0] resData;

  int testCnt = 0;
  int failCnt = 0;
  logic [DW-1:0] elem [MAXN];

  always #2.5 clk = ~clk;

  cascade_sum_top #(.LANES(P), .DATA_W(DW), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .inValid(inValid),
    .inData(inData), .inReady(inReady), .resValid(resValid), .resData(resData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expBeats(input int n);
    int rem = n % (2 * P);
    return (n / (2 * P)) * P + ((rem < P) ? rem : P);
  endfunction

  function automatic logic [DW-1:0] expSum(input int n);
    logic [DW-1:0] s = '0;
    for (int i = 0; i < n; i++) s = s + elem[i];
    return s;
  endfunction

  task automatic runJob(input int n, input bit allMax, input int stallPct, input bit poke);
    int beats = 0, lastNeg = 0, seenNeg = -1, lowPos, highPos;
    logic [DW-1:0] gotSum, exp;
    for (int i = 0; i < MAXN; i++) elem[i] = allMax ? 16'h7FFF : DW'($urandom);
    exp = expSum(n);
    @(negedge clk);
    start = 1'b1;
    len = LW'(n);
    for (int negIdx = 1; negIdx < 2000; negIdx++) begin
      @(negedge clk);
      start = poke && (negIdx == 3);
      len = poke ? LW'(5) : LW'(n);
      if (resValid) begin
        seenNeg = negIdx;
        gotSum = resData;
        break;
      end
      lowPos = (beats / P) * 2 * P + (beats % P);
      highPos = lowPos + P;
      inValid = ($urandom % 100) >= stallPct;
      inData[DW-1:0] = (lowPos < n) ? elem[lowPos] : DW'($urandom);
      inData[2*DW-1:DW] = (highPos < n) ? elem[highPos] : DW'($urandom);
      #1;
      if (inValid && inReady) begin
        beats++;
        lastNeg = negIdx;
      end
    end
    inValid = 1'b0;
    start = 1'b0;
    check(seenNeg > 0, "R5 result produced", seenNeg, 1);
    check(beats == expBeats(n), n == 0 ? "R7 beats on empty run" : "R2 beat count",
          beats, expBeats(n));
    check(gotSum == exp, n == 0 ? "R7 empty sum" : "R5 R3 R4 sum", int'(gotSum), int'(exp));
    check(seenNeg == lastNeg + LOGP + 2, "R6 latency", seenNeg - lastNeg, LOGP + 2);
    @(negedge clk);
    check(!resValid, "R8 pulse width", int'(resValid), 0);
    repeat (3) @(negedge clk);
    check(resData == exp, "R8 result held", int'(resData), int'(exp));
    check(!inReady, "R2 ready idle", int'(inReady), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!inReady && !resValid, "R1 in reset", int'({inReady, resValid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!inReady && !resValid, "R1 after reset", int'({inReady, resValid}), 0);
    runJob(0, 1'b0, 0, 1'b0);    // R7
    runJob(1, 1'b0, 0, 1'b0);    // R4 only low half of lane 0
    runJob(3, 1'b0, 0, 1'b0);
    runJob(P, 1'b0, 0, 1'b0);    // R4 all high halves masked
    runJob(P + 1, 1'b0, 0, 1'b0);
    runJob(2 * P, 1'b0, 20, 1'b0);
    runJob(2 * P + 1, 1'b0, 20, 1'b0);
    runJob(13, 1'b0, 40, 1'b0);
    runJob(40, 1'b1, 10, 1'b0);  // R5 wrap
    runJob(30, 1'b0, 30, 1'b1);  // R9 start while busy
    for (int j = 0; j < 12; j++) runJob($urandom % 100, 1'b0, 30, j[0]);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule